// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a synchronous DRAM interface on every rising clock edge. It turns each sampled combination of chip select, row strobe, column strobe, write enable, bank select and address bit 10 into one registered one-cycle pulse. For each of four banks it also keeps an open/idle flag and the row that the bank has open. The pulses cover activate, read, write, single-bank precharge, precharge of every bank, burst stop, auto refresh and mode register load.

Alongside the pulses the block reports the bank and the column of the last access. It also outputs the mode register fields that were taken from the address bus. An error pulse marks commands that do not fit the tracked bank state, and such commands leave that state as it was. The block is meant for a memory model or a protocol monitor that sits next to a controller and needs a decoded view of the command stream.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: While cs_n is sampled high, no pulse is produced and neither the bank state, the rows nor the mode fields change, whatever the other pins carry.
- R2: Code {ras_n,cas_n,we_n}=011 with cs_n low is an activate. If the selected bank is idle, act_p pulses, that bank becomes active and its open row becomes addr[10:0].
- R3: Code 010 with addr[10] low is a single-bank precharge. pre_p pulses, the bank given by ba becomes idle, and the other banks keep their state.
- R4: Code 010 with addr[10] high pulses pre_all_p (pre_p stays low) and makes all four banks idle.
- R5: Code 101 pulses rd_p and code 100 pulses wr_p. Both load cmd_bank from ba and cmd_col from addr[7:0]. Activate and precharge also load cmd_bank.
- R6: A read or write to an active bank with addr[10] high pulses ap_p and leaves that bank idle afterwards. Without addr[10], the bank stays active.
- R7: Code 110 pulses bst_p and changes no tracked state.
- R8: Code 001 pulses ref_p. It is flagged with err_p when any bank is active.
- R9: Code 000 pulses mrs_p and, when all banks are idle, loads the mode fields: burst length code = addr[2:0], burst type = addr[3], CAS latency = addr[6:4], write burst mode = addr[9].
- R10: err_p pulses for an activate to an active bank, a read or write to an idle bank, and a mode load while any bank is active. The erroneous command still gives its own pulse, but it changes no bank flag, row or mode field, and ap_p stays low.
- R11: While rst_n is low, all pulses and err_p are 0, all banks are idle, rows, cmd_bank and cmd_col are 0, and all mode fields are 0.
- R12: Every output reflects the command sampled on the previous rising edge. Pulses last exactly one cycle unless the next command repeats them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Address bus; bit 10 selects all-bank / auto-precharge |
| act_p | output | 1 | Activate decoded |
| rd_p | output | 1 | Read decoded |
| wr_p | output | 1 | Write decoded |
| pre_p | output | 1 | Single-bank precharge decoded |
| pre_all_p | output | 1 | All-bank precharge decoded |
| bst_p | output | 1 | Burst stop decoded |
| mrs_p | output | 1 | Mode load decoded |
| ref_p | output | 1 | Auto refresh decoded |
| ap_p | output | 1 | Accepted access with auto-precharge |
| err_p | output | 1 | Command illegal for current bank state |
| cmd_bank | output | 2 | Bank of last bank-addressed command |
| cmd_col | output | 8 | Column of last read or write |
| bank_active | output | 4 | Open flag per bank, bit i = bank i |
| open_rows | output | 44 | Open row per bank, bank i at bits [11*i+10 : 11*i] |
| mode_bl | output | 3 | Burst length code |
| mode_bt | output | 1 | Burst type |
| mode_cl | output | 3 | CAS latency |
| mode_wb | output | 1 | Write burst mode |

## Verification
The hardest situations to reach are those where an illegal command meets a specific mix of open and idle banks. Examples are a mode load or refresh while only one bank is open, a second activate that must not move the stored row, and an auto-precharge access aimed at a bank that is already idle. A directed sequence first builds such mixes, opening banks 0 and 2 and leaving 1 and 3 idle, and then aims every error case at them. After that, a long pseudo-random command stream that favours activate and precharge keeps the banks in changing mixed states. A behavioural model compares every output on every cycle.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  localparam int ADDR_W = 11;
  localparam int AP_BIT = 10;

  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_BST,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef struct packed {
    logic       wb;
    logic [2:0] cl;
    logic       bt;
    logic [2:0] bl;
  } mode_t;

  // Translate sampled strobes into a command kind.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Pick the mode fields out of the address bus.
  function automatic mode_t unpack_mode(input logic [ADDR_W-1:0] a);
    mode_t m;
    m.bl = a[2:0];
    m.bt = a[3];
    m.cl = a[6:4];
    m.wb = a[9];
    return m;
  endfunction

  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd_now,
  output logic act_p,
  output logic rd_p,
  output logic wr_p,
  output logic pre_p,
  output logic pre_all_p,
  output logic bst_p,
  output logic mrs_p,
  output logic ref_p
);

  assign cmd_now = decode_cmd(cs_n, ras_n, cas_n, we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_p     <= 1'b0;
      rd_p      <= 1'b0;
      wr_p      <= 1'b0;
      pre_p     <= 1'b0;
      pre_all_p <= 1'b0;
      bst_p     <= 1'b0;
      mrs_p     <= 1'b0;
      ref_p     <= 1'b0;
    end else begin
      act_p     <= (cmd_now == CMD_ACT);
      rd_p      <= (cmd_now == CMD_RD);
      wr_p      <= (cmd_now == CMD_WR);
      pre_p     <= (cmd_now == CMD_PRE) && !a10;
      pre_all_p <= (cmd_now == CMD_PRE) && a10;
      bst_p     <= (cmd_now == CMD_BST);
      mrs_p     <= (cmd_now == CMD_MRS);
      ref_p     <= (cmd_now == CMD_REF);
    end
  end

  // R12: at most one decoded pulse per cycle
  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_p, rd_p, wr_p, pre_p, pre_all_p, bst_p, mrs_p, ref_p}));

  // R1: a deselected cycle yields no pulse on the next cycle
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(act_p || rd_p || wr_p || pre_p || pre_all_p || bst_p || mrs_p || ref_p));

endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_ev,
  input  logic             close_ev,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
    end else if (open_ev) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (close_ev) begin
      active <= 1'b0;
    end
  end

  // R10: an open bank's row never moves while it stays open
  a_r10_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(row));

  // R2: opening an idle bank leaves it active on the next cycle
  a_r2_open_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (open_ev && !close_ev) |=> active);

endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_trk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (load) mode <= unpack_mode(addr);
  end

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [1:0]                 ba,
  input  logic [10:0]                addr,
  output logic                       act_p,
  output logic                       rd_p,
  output logic                       wr_p,
  output logic                       pre_p,
  output logic                       pre_all_p,
  output logic                       bst_p,
  output logic                       mrs_p,
  output logic                       ref_p,
  output logic                       ap_p,
  output logic                       err_p,
  output logic [1:0]                 cmd_bank,
  output logic [7:0]                 cmd_col,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [2:0]                 mode_bl,
  output logic                       mode_bt,
  output logic [2:0]                 mode_cl,
  output logic                       mode_wb
);

  localparam int BA_W = $clog2(NUM_BANKS);

  cmd_e               cmd_now;
  logic               a10;
  logic               any_active;
  logic               sel_active;
  logic               col_cmd;
  logic               err_now;
  logic               ap_now;
  logic               mode_load;
  logic [NUM_BANKS-1:0] open_ev;
  logic [NUM_BANKS-1:0] close_ev;
  mode_t              mode;

  assign a10        = addr[AP_BIT];
  assign any_active = |bank_active;
  assign sel_active = bank_active[ba[BA_W-1:0]];
  assign col_cmd    = is_column(cmd_now);
  assign err_now    = ((cmd_now == CMD_ACT) && sel_active)
                    || (col_cmd && !sel_active)
                    || (((cmd_now == CMD_REF) || (cmd_now == CMD_MRS)) && any_active);
  assign ap_now     = col_cmd && a10 && sel_active;
  assign mode_load  = (cmd_now == CMD_MRS) && !any_active;

  sdr_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .a10       (a10),
    .cmd_now   (cmd_now),
    .act_p     (act_p),
    .rd_p      (rd_p),
    .wr_p      (wr_p),
    .pre_p     (pre_p),
    .pre_all_p (pre_all_p),
    .bst_p     (bst_p),
    .mrs_p     (mrs_p),
    .ref_p     (ref_p)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic sel;
    assign sel         = (ba[BA_W-1:0] == BA_W'(i));
    assign open_ev[i]  = (cmd_now == CMD_ACT) && sel && !bank_active[i];
    assign close_ev[i] = ((cmd_now == CMD_PRE) && (a10 || sel)) || (ap_now && sel);

    sdr_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_ev  (open_ev[i]),
      .close_ev (close_ev[i]),
      .row_in   (addr[ROW_W-1:0]),
      .active   (bank_active[i]),
      .row      (open_rows[i*ROW_W +: ROW_W])
    );
  end

  sdr_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .addr  (addr),
    .mode  (mode)
  );

  assign mode_bl = mode.bl;
  assign mode_bt = mode.bt;
  assign mode_cl = mode.cl;
  assign mode_wb = mode.wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_p    <= 1'b0;
      ap_p     <= 1'b0;
      cmd_bank <= '0;
      cmd_col  <= '0;
    end else begin
      err_p <= err_now;
      ap_p  <= ap_now;
      if ((cmd_now == CMD_ACT) || (cmd_now == CMD_PRE) || col_cmd) cmd_bank <= ba;
      if (col_cmd) cmd_col <= addr[COL_W-1:0];
    end
  end

  // R4: after an all-bank precharge every bank is idle
  a_r4_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_p |-> (bank_active == '0));

  // R10: a rejected column access leaves the bank flags untouched
  a_r10_col_err_still: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_p || wr_p) && err_p) |-> $stable(bank_active));

  // R10: a rejected activate leaves every row untouched
  a_r10_act_err_still: assert property (@(posedge clk) disable iff (!rst_n)
    (act_p && err_p) |-> $stable(open_rows));

  // R9: mode fields only move together with a mode-load pulse
  a_r9_mode_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_p |-> $stable({mode_wb, mode_cl, mode_bt, mode_bl}));

  // R6: auto-precharge is only reported on a column command
  a_r6_ap_with_col: assert property (@(posedge clk) disable iff (!rst_n)
    ap_p |-> ((rd_p || wr_p) && !err_p));

endmodule

// File: tb/sdr_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdr_cmd_tracker_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [10:0] addr = '0;

  logic act_p, rd_p, wr_p, pre_p, pre_all_p, bst_p, mrs_p, ref_p, ap_p, err_p;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_col;
  logic [3:0] bank_active;
  logic [43:0] open_rows;
  logic [2:0] mode_bl, mode_cl;
  logic mode_bt, mode_wb;

  always #2 clk = ~clk;

  sdr_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .act_p(act_p), .rd_p(rd_p), .wr_p(wr_p), .pre_p(pre_p),
    .pre_all_p(pre_all_p), .bst_p(bst_p), .mrs_p(mrs_p), .ref_p(ref_p), .ap_p(ap_p),
    .err_p(err_p), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .bank_active(bank_active),
    .open_rows(open_rows), .mode_bl(mode_bl), .mode_bt(mode_bt), .mode_cl(mode_cl),
    .mode_wb(mode_wb)
  );

  // Behavioural reference state
  bit [3:0]  m_act;
  bit [10:0] m_row [4];
  bit [8:0]  m_pulse;   // act rd wr pre preall bst mrs ref ap
  bit        m_err;
  bit [1:0]  m_bank;
  bit [7:0]  m_col;
  bit [7:0]  m_mode;    // wb cl bt bl

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pulse = 0; m_err = 0; m_bank = 0; m_col = 0; m_mode = 0;
      for (int i = 0; i < 4; i++) m_row[i] = 0;
    end else begin
      m_pulse = 0; m_err = 0;
      if (!cs_n) begin
        case ({ras_n, cas_n, we_n})
          3'b011: begin
            m_pulse[8] = 1; m_bank = ba;
            if (m_act[ba]) m_err = 1;
            else begin m_act[ba] = 1; m_row[ba] = addr; end
          end
          3'b010: begin
            m_bank = ba;
            if (addr[10]) begin m_pulse[4] = 1; m_act = 0; end
            else begin m_pulse[5] = 1; m_act[ba] = 0; end
          end
          3'b101, 3'b100: begin
            if (we_n) m_pulse[7] = 1; else m_pulse[6] = 1;
            m_bank = ba; m_col = addr[7:0];
            if (!m_act[ba]) m_err = 1;
            else if (addr[10]) begin m_pulse[0] = 1; m_act[ba] = 0; end
          end
          3'b110: m_pulse[3] = 1;
          3'b001: begin m_pulse[1] = 1; m_err = (m_act != 0); end
          3'b000: begin
            m_pulse[2] = 1;
            if (m_act != 0) m_err = 1;
            else m_mode = {addr[9], addr[6:4], addr[3], addr[2:0]};
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("pulses", {act_p, rd_p, wr_p, pre_p, pre_all_p, bst_p, mrs_p, ref_p, ap_p}, m_pulse);
      chk("err", err_p, m_err);
      chk("bank", cmd_bank, m_bank);
      chk("col", cmd_col, m_col);
      chk("active", bank_active, m_act);
      chk("rows", open_rows, {m_row[3], m_row[2], m_row[1], m_row[0]});
      chk("mode", {mode_wb, mode_cl, mode_bt, mode_bl}, m_mode);
    end
  end

  task automatic issue(input string req, input bit c, input bit r, input bit ca,
                       input bit w, input bit [1:0] b, input bit [10:0] a);
    @(negedge clk);
    cur_req = req;
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
  endtask

  task automatic idle(input string req);
    issue(req, 0, 1, 1, 1, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: deselect with activate/refresh/mode patterns on the strobes
    issue("R1", 1, 0, 1, 1, 2, 11'h123);
    issue("R1", 1, 0, 0, 0, 0, 11'h3FF);
    issue("R1", 1, 1, 0, 1, 1, 11'h055);
    // R9: mode load with all idle
    issue("R9", 0, 0, 0, 0, 0, 11'h232);
    idle("R9");
    // R2: open bank 0 and bank 2
    issue("R2", 0, 0, 1, 1, 0, 11'h5A3);
    issue("R2", 0, 0, 1, 1, 2, 11'h7FF);
    // R10: second activate to bank 0
    issue("R10", 0, 0, 1, 1, 0, 11'h001);
    // R5: read bank 0, write bank 2
    issue("R5", 0, 1, 0, 1, 0, 11'h0C4);
    issue("R5", 0, 1, 0, 0, 2, 11'h03B);
    // R10: read of idle bank 1, write with ap to idle bank 3
    issue("R10", 0, 1, 0, 1, 1, 11'h011);
    issue("R10", 0, 1, 0, 0, 3, 11'h4FE);
    // R7: burst stop
    issue("R7", 0, 1, 1, 0, 1, 11'h000);
    // R8: refresh with banks open
    issue("R8", 0, 0, 0, 1, 0, 11'h000);
    // R10: mode load while banks open is ignored
    issue("R10", 0, 0, 0, 0, 0, 11'h275);
    // R3: single precharge bank 2, and of idle bank 1
    issue("R3", 0, 0, 1, 0, 2, 11'h000);
    issue("R3", 0, 0, 1, 0, 1, 11'h3FF);
    // R6: write bank 0 with auto-precharge, then read without it
    issue("R6", 0, 1, 0, 0, 0, 11'h480);
    issue("R6", 0, 0, 1, 1, 3, 11'h2AA);
    issue("R6", 0, 1, 0, 1, 3, 11'h07F);
    // R4: open more, then precharge all
    issue("R4", 0, 0, 1, 1, 1, 11'h111);
    issue("R4", 0, 0, 1, 0, 0, 11'h400);
    // R8: refresh with all idle
    issue("R8", 0, 0, 0, 1, 2, 11'h000);
    // R9: second mode load
    issue("R9", 0, 0, 0, 0, 3, 11'h20B);
    idle("R9");
    // R12: pseudo-random stream favouring bank commands
    for (int k = 0; k < 2000; k++) begin
      int sel = $urandom_range(0, 15);
      bit [10:0] a = 11'($urandom);
      bit [1:0] b = 2'($urandom);
      if ($urandom_range(0, 3) != 0) a[10] = 1'b0;
      case (sel)
        0, 1, 2, 3: issue("R12", 0, 0, 1, 1, b, a);
        4, 5:       issue("R12", 0, 0, 1, 0, b, a);
        6, 7:       issue("R12", 0, 1, 0, 1, b, a);
        8, 9:       issue("R12", 0, 1, 0, 0, b, a);
        10:         issue("R12", 0, 1, 1, 0, b, a);
        11:         issue("R12", 0, 0, 0, 1, b, a);
        12:         issue("R12", 0, 0, 0, 0, b, a);
        13:         issue("R12", 1, 1'($urandom), 1'($urandom), 1'($urandom), b, a);
        default:    issue("R12", 0, 1, 1, 1, b, a);
      endcase
    end
    idle("R12");
    // R11: reset in the middle of activity
    issue("R11", 0, 0, 1, 1, 1, 11'h0F0);
    @(negedge clk);
    cur_req = "R11";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R11");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule